// File: doc/BRIEF.md
# Link Auto-Negotiation Arbitration Controller

This block runs the capability exchange between two ends of a twisted-pair link. It builds the local 16-bit link code word and hands it to a burst transmitter. It takes the words that a burst receiver decodes, works out the best speed and duplex mode both ends support, and then sends its own word with the acknowledge bit set. When the partner has confirmed with enough acknowledged words that match, it declares link and reports the mode.

Negotiation starts when the block leaves reset or is enabled. It starts again on a restart strobe or on any of a set of trigger lines. These lines stand for the various reset, power-down exit, link-loss and reload events. Software loads a four-bit advertisement register. Writes to that register stay inert until the next explicit restart or trigger. A partner word that changes during the acknowledge phase restarts the exchange, and so does a silence longer than a parameterized window. If the two ends share no ability, the block flags a resolution failure and does not assert link.

Top module: `autoneg_arbiter`

## Requirements
- R1: While `anEnable` is low, or during reset, `txActive`, `txWord`, `linkUp`, `modeSpeed100`, `modeFullDuplex` and `resolveFail` are all 0. Received words are then ignored. The advertisement register resets to 4'b1111.
- R2: One cycle after reset ends with `anEnable` high, after `anEnable` rises, after a `restartWr` pulse, or after any `trigIn` bit is high, the block is in the ability phase. In that phase `txActive` is 1 and `txWord` is {1'b0, ack=0 (bit 14), 5'b0, abilities in bits 8:5, selector 5'b00001 in bits 4:0}. The ability bit order is bit5=10 half, bit6=10 full, bit7=100 half, bit8=100 full.
- R3: A write through `advWr`/`advData` does not change the transmitted abilities. The new value is advertised only after the next restart or trigger.
- R4: The common set is the local abilities AND the partner's bits 8:5. The resolved mode is the highest set bit of the common set, in priority order 100 full, 100 half, 10 full, 10 half. `modeSpeed100` and `modeFullDuplex` show this mode only while `linkUp` is 1.
- R5: A received word with selector 00001 and a non-empty common set moves the block to the acknowledge phase. In that phase `txWord` bit 14 is 1 and the other bits are unchanged.
- R6: In the acknowledge phase, link is declared after 3 received words that match the stored partner content (bit 14 excluded) and carry bit 14 set. Matching words with bit 14 clear do not count. Once link is up, `txActive` and `txWord` are 0.
- R7: In the acknowledge phase, a received word whose content outside bit 14 differs from the stored partner word returns the block to the ability phase with ack clear.
- R8: If no valid word arrives for `TIMEOUT_CYC` cycles in the acknowledge phase, the block returns to the ability phase with ack clear.
- R9: A valid partner word with an empty common set sets `resolveFail`, leaves `linkUp` at 0 and stops transmission, until the next restart or trigger.
- R10: Received words whose selector is not 00001 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset (power-on / hardware reset) |
| anEnable | input | 1 | Auto-negotiation enable; low disables the process |
| restartWr | input | 1 | One-cycle restart strobe (self-clearing restart bit) |
| trigIn | input | NUM_TRIG | Restart trigger events, any bit high restarts |
| advWr | input | 1 | Advertisement register write strobe |
| advData | input | 4 | Advertisement value {100F,100H,10F,10H} |
| rxValid | input | 1 | Received word strobe from burst receiver |
| rxWord | input | 16 | Received link code word |
| txActive | output | 1 | Transmitter should send `txWord` |
| txWord | output | 16 | Local link code word |
| linkUp | output | 1 | Negotiation complete, link declared |
| modeSpeed100 | output | 1 | Resolved speed is 100 (valid with linkUp) |
| modeFullDuplex | output | 1 | Resolved duplex is full (valid with linkUp) |
| resolveFail | output | 1 | No common ability found |

## Verification
The bench writes the advertisement register while negotiation is under way. It then checks that the transmitted abilities stay the same until a restart. A design that latched the register directly would advertise too early. It places non-acknowledged matching words and bad-selector words between acknowledgements. This catches a counter that counts every word, or a design that restarts on garbage. It drives partner sets that resolve to 100 full, 100 half and 10 half, plus one set with no overlap, so a wrong priority order or a missing failure path shows up as the wrong mode or a false link. It samples one cycle before and exactly at the end of the silence window, which exposes an off-by-one in the timeout. It also sends a changed partner word during the acknowledge phase, which must fall back to the ability phase.

// File: rtl/an_pkg.sv
package an_pkg;
  localparam int WORD_W   = 16;
  localparam int SEL_W    = 5;
  localparam int ABIL_W   = 4;
  localparam int ABIL_LSB = 5;
  localparam int ACK_POS  = 14;
  localparam logic [SEL_W-1:0] SEL_CODE = 5'b00001;

  typedef struct packed {
    logic loadAdv;
    logic capture;
    logic runTimer;
    logic clrTimer;
    logic clrAck;
    logic incAck;
    logic txOn;
    logic ackOn;
  } anCtrl_t;

  typedef enum logic [2:0] {
    ST_OFF, ST_ABIL, ST_ACKN, ST_LINK, ST_FAIL
  } anState_t;
endpackage

// File: rtl/an_datapath.sv
module an_datapath
  import an_pkg::*;
#(
  parameter logic [ABIL_W-1:0] ADV_RESET = 4'b1111,
  parameter int TIMEOUT_CYC = 2000,
  parameter int ACK_NEEDED  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  anCtrl_t           ctrl,
  input  logic              advWr,
  input  logic [ABIL_W-1:0] advData,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] txWord,
  output logic              rxSelOk,
  output logic              rxCommonNz,
  output logic              rxMatch,
  output logic              rxAck,
  output logic              ackLast,
  output logic              timeout,
  output logic              dpSpeed100,
  output logic              dpFull
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam int ACK_W = $clog2(ACK_NEEDED + 1);
  localparam logic [WORD_W-1:0] ACK_MASK = {{(WORD_W-1){1'b0}}, 1'b1} << ACK_POS;

  logic [ABIL_W-1:0] advReg;
  logic [ABIL_W-1:0] txAbility;
  logic [WORD_W-1:0] partnerContent;
  logic [TMR_W-1:0]  timer;
  logic [ACK_W-1:0]  ackCnt;
  logic [ABIL_W-1:0] common;
  logic [WORD_W-1:0] rxContent;
  logic [1:0]        bestIdx;

  assign rxSelOk    = rxWord[SEL_W-1:0] == SEL_CODE;
  assign common     = txAbility & rxWord[ABIL_LSB +: ABIL_W];
  assign rxCommonNz = |common;
  assign rxContent  = rxWord & ~ACK_MASK;
  assign rxMatch    = rxContent == partnerContent;
  assign rxAck      = rxWord[ACK_POS];
  assign ackLast    = ackCnt == ACK_W'(ACK_NEEDED - 1);
  assign timeout    = timer == TMR_W'(TIMEOUT_CYC - 1);

  // priority pick: later (higher) index wins
  always_comb begin
    bestIdx = 2'd0;
    for (int i = 0; i < ABIL_W; i++) begin
      if (common[i]) bestIdx = 2'(i);
    end
  end

  always_comb begin
    txWord = '0;
    if (ctrl.txOn) begin
      txWord[SEL_W-1:0]            = SEL_CODE;
      txWord[ABIL_LSB +: ABIL_W]   = txAbility;
      txWord[ACK_POS]              = ctrl.ackOn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      advReg         <= ADV_RESET;
      txAbility      <= ADV_RESET;
      partnerContent <= '0;
      dpSpeed100     <= 1'b0;
      dpFull         <= 1'b0;
    end else begin
      if (advWr) advReg <= advData;
      if (ctrl.loadAdv) txAbility <= advReg;
      if (ctrl.capture) begin
        partnerContent <= rxContent;
        dpSpeed100     <= bestIdx[1];
        dpFull         <= bestIdx[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer  <= '0;
      ackCnt <= '0;
    end else begin
      if (ctrl.clrTimer)      timer <= '0;
      else if (ctrl.runTimer) timer <= timer + 1'b1;
      if (ctrl.clrAck)        ackCnt <= '0;
      else if (ctrl.incAck)   ackCnt <= ackCnt + 1'b1;
    end
  end
endmodule

// File: rtl/an_control.sv
module an_control
  import an_pkg::*;
#(
  parameter int NUM_TRIG = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                anEnable,
  input  logic                restartWr,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                rxValid,
  input  logic                rxSelOk,
  input  logic                rxCommonNz,
  input  logic                rxMatch,
  input  logic                rxAck,
  input  logic                ackLast,
  input  logic                timeout,
  output anCtrl_t             ctrl,
  output logic                linkUp,
  output logic                resolveFail
);
  anState_t state, nxt;
  logic restartEv;
  logic rxGood;

  assign restartEv = restartWr | (|trigIn);
  assign rxGood    = rxValid & rxSelOk;

  always_comb begin
    nxt           = state;
    ctrl          = '0;
    ctrl.txOn     = (state == ST_ABIL) || (state == ST_ACKN);
    ctrl.ackOn    = state == ST_ACKN;
    ctrl.runTimer = ctrl.txOn;
    if (!anEnable) begin
      nxt = ST_OFF;
    end else if (state == ST_OFF || restartEv) begin
      nxt          = ST_ABIL;
      ctrl.loadAdv = 1'b1;
      ctrl.clrTimer = 1'b1;
      ctrl.clrAck  = 1'b1;
    end else begin
      unique case (state)
        ST_ABIL: begin
          if (rxGood) begin
            ctrl.capture  = 1'b1;
            ctrl.clrTimer = 1'b1;
            ctrl.clrAck   = 1'b1;
            nxt = rxCommonNz ? ST_ACKN : ST_FAIL;
          end else if (timeout) begin
            ctrl.clrTimer = 1'b1;
          end
        end
        ST_ACKN: begin
          if (rxGood) begin
            ctrl.clrTimer = 1'b1;
            if (!rxMatch) begin
              ctrl.clrAck = 1'b1;
              nxt = ST_ABIL;
            end else if (rxAck) begin
              ctrl.incAck = 1'b1;
              if (ackLast) nxt = ST_LINK;
            end
          end else if (timeout) begin
            ctrl.clrTimer = 1'b1;
            ctrl.clrAck   = 1'b1;
            nxt = ST_ABIL;
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxt;
  end

  assign linkUp      = state == ST_LINK;
  assign resolveFail = state == ST_FAIL;
endmodule

// File: rtl/autoneg_arbiter.sv
module autoneg_arbiter
  import an_pkg::*;
#(
  parameter int NUM_TRIG    = 6,
  parameter int TIMEOUT_CYC = 2000,
  parameter int ACK_NEEDED  = 3,
  parameter logic [3:0] ADV_RESET = 4'b1111
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                anEnable,
  input  logic                restartWr,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                advWr,
  input  logic [3:0]          advData,
  input  logic                rxValid,
  input  logic [15:0]         rxWord,
  output logic                txActive,
  output logic [15:0]         txWord,
  output logic                linkUp,
  output logic                modeSpeed100,
  output logic                modeFullDuplex,
  output logic                resolveFail
);
  anCtrl_t ctrl;
  logic rxSelOk, rxCommonNz, rxMatch, rxAck, ackLast, timeout;
  logic dpSpeed100, dpFull;

  an_control #(.NUM_TRIG(NUM_TRIG)) i_ctrl (
    .clk(clk), .rstN(rstN), .anEnable(anEnable), .restartWr(restartWr),
    .trigIn(trigIn), .rxValid(rxValid), .rxSelOk(rxSelOk),
    .rxCommonNz(rxCommonNz), .rxMatch(rxMatch), .rxAck(rxAck),
    .ackLast(ackLast), .timeout(timeout), .ctrl(ctrl),
    .linkUp(linkUp), .resolveFail(resolveFail)
  );

  an_datapath #(
    .ADV_RESET(ADV_RESET), .TIMEOUT_CYC(TIMEOUT_CYC), .ACK_NEEDED(ACK_NEEDED)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .advWr(advWr), .advData(advData),
    .rxWord(rxWord), .txWord(txWord), .rxSelOk(rxSelOk),
    .rxCommonNz(rxCommonNz), .rxMatch(rxMatch), .rxAck(rxAck),
    .ackLast(ackLast), .timeout(timeout), .dpSpeed100(dpSpeed100),
    .dpFull(dpFull)
  );

  assign txActive       = ctrl.txOn;
  assign modeSpeed100   = linkUp & dpSpeed100;
  assign modeFullDuplex = linkUp & dpFull;
endmodule

// File: rtl/an_checker.sv
module an_checker #(
  parameter int NUM_TRIG = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                anEnable,
  input logic                restartWr,
  input logic [NUM_TRIG-1:0] trigIn,
  input logic                advWr,
  input logic                rxValid,
  input logic                txActive,
  input logic [15:0]         txWord,
  input logic                linkUp,
  input logic                modeSpeed100,
  input logic                modeFullDuplex,
  input logic                resolveFail
);
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !anEnable |=> (txWord == 16'h0) && !linkUp && !resolveFail && !txActive);

  assert_restart_fresh_R2: assert property (@(posedge clk) disable iff (!rstN)
    (anEnable && (restartWr || (|trigIn))) |=>
      txActive && !txWord[14] && (txWord[4:0] == 5'b00001) && !linkUp);

  assert_adv_write_inert_R3: assert property (@(posedge clk) disable iff (!rstN)
    (advWr && anEnable && !restartWr && !(|trigIn) && txActive) |=>
      (!txActive || (txWord[8:5] == $past(txWord[8:5]))));

  assert_mode_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp && $past(linkUp)) |->
      ($stable(modeSpeed100) && $stable(modeFullDuplex)));

  assert_link_needs_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |-> $past(rxValid));

  assert_link_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    linkUp |-> !txActive);

  assert_fail_no_link_R9: assert property (@(posedge clk) disable iff (!rstN)
    resolveFail |-> !linkUp && !txActive);
endmodule

bind autoneg_arbiter an_checker #(.NUM_TRIG(NUM_TRIG)) i_chk (
  .clk(clk), .rstN(rstN), .anEnable(anEnable), .restartWr(restartWr),
  .trigIn(trigIn), .advWr(advWr), .rxValid(rxValid), .txActive(txActive),
  .txWord(txWord), .linkUp(linkUp), .modeSpeed100(modeSpeed100),
  .modeFullDuplex(modeFullDuplex), .resolveFail(resolveFail)
);

// File: tb/test_autoneg_arbiter.sv
`timescale 1ns/1ps
module test_autoneg_arbiter;
  localparam int NT = 6;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic anEnable = 1'b0, restartWr = 1'b0, advWr = 1'b0, rxValid = 1'b0;
  logic [NT-1:0] trigIn = '0;
  logic [3:0] advData = '0;
  logic [15:0] rxWord = '0;
  logic txActive, linkUp, modeSpeed100, modeFullDuplex, resolveFail;
  logic [15:0] txWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  autoneg_arbiter #(.NUM_TRIG(NT), .TIMEOUT_CYC(TMO), .ACK_NEEDED(3)) i_autoneg_arbiter (
    .clk(clk), .rstN(rstN), .anEnable(anEnable), .restartWr(restartWr),
    .trigIn(trigIn), .advWr(advWr), .advData(advData), .rxValid(rxValid),
    .rxWord(rxWord), .txActive(txActive), .txWord(txWord), .linkUp(linkUp),
    .modeSpeed100(modeSpeed100), .modeFullDuplex(modeFullDuplex),
    .resolveFail(resolveFail)
  );

  typedef struct {
    string tag;
    logic [15:0] tx;
    logic lk, sp, fd, fl;
  } exp_t;
  exp_t q[$];
  event chkEv;

  function automatic logic [15:0] pw(input logic [3:0] ab, input logic ack);
    pw = 16'h0001 | (16'(ab) << 5) | (16'(ack) << 14);
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expectNow(input string tag, input logic [15:0] tx,
                           input logic lk, input logic sp, input logic fd, input logic fl);
    exp_t e;
    e.tag = tag; e.tx = tx; e.lk = lk; e.sp = sp; e.fd = fd; e.fl = fl;
    q.push_back(e);
    ->chkEv;
    #1;
  endtask

  task automatic sendRx(input logic [15:0] w);
    rxValid = 1'b1; rxWord = w;
    tick();
    rxValid = 1'b0; rxWord = '0;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @chkEv;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (txWord !== e.tx || txActive !== (e.tx != 16'h0) || linkUp !== e.lk ||
            modeSpeed100 !== e.sp || modeFullDuplex !== e.fd || resolveFail !== e.fl) begin
          bad++;
          $display("FAIL %s: got tx=%h act=%b lk=%b sp=%b fd=%b fl=%b exp tx=%h lk=%b sp=%b fd=%b fl=%b",
                   e.tag, txWord, txActive, linkUp, modeSpeed100, modeFullDuplex, resolveFail,
                   e.tx, e.lk, e.sp, e.fd, e.fl);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    expectNow("R1 in reset", 16'h0, 0, 0, 0, 0);
    rstN = 1'b1;
    tick();
    expectNow("R1 disabled after reset", 16'h0, 0, 0, 0, 0);

    anEnable = 1'b1; tick();
    expectNow("R2 enable starts ability phase", pw(4'hF, 0), 0, 0, 0, 0);

    advWr = 1'b1; advData = 4'b0011; tick(); advWr = 1'b0;
    expectNow("R3 adv write inert", pw(4'hF, 0), 0, 0, 0, 0);

    sendRx(pw(4'hF, 0));
    expectNow("R5 ack phase after common word", pw(4'hF, 1), 0, 0, 0, 0);

    sendRx(pw(4'h2, 0) & 16'hFFE0);
    expectNow("R10 bad selector ignored", pw(4'hF, 1), 0, 0, 0, 0);

    sendRx(pw(4'hF, 1));
    sendRx(pw(4'hF, 0));
    expectNow("R6 unacked word not counted", pw(4'hF, 1), 0, 0, 0, 0);
    sendRx(pw(4'hF, 1));
    expectNow("R6 two acks no link", pw(4'hF, 1), 0, 0, 0, 0);
    sendRx(pw(4'hF, 1));
    expectNow("R6 R4 link at third ack 100F", 16'h0, 1, 1, 1, 0);

    restartWr = 1'b1; tick(); restartWr = 1'b0;
    expectNow("R3 R2 restart advertises new value", pw(4'h3, 0), 0, 0, 0, 0);

    sendRx(pw(4'b0101, 0));
    expectNow("R5 ack phase", pw(4'h3, 1), 0, 0, 0, 0);
    repeat (3) sendRx(pw(4'b0101, 1));
    expectNow("R4 resolve 10 half", 16'h0, 1, 0, 0, 0);

    trigIn[2] = 1'b1; tick(); trigIn = '0;
    expectNow("R2 trigger restarts from link", pw(4'h3, 0), 0, 0, 0, 0);

    sendRx(pw(4'b1100, 0));
    expectNow("R9 no common ability fails", 16'h0, 0, 0, 0, 1);
    sendRx(pw(4'b0011, 0));
    expectNow("R9 fail holds", 16'h0, 0, 0, 0, 1);

    advWr = 1'b1; advData = 4'b1100; tick(); advWr = 1'b0;
    restartWr = 1'b1; tick(); restartWr = 1'b0;
    expectNow("R2 restart from fail", pw(4'hC, 0), 0, 0, 0, 0);

    sendRx(pw(4'b0110, 0));
    expectNow("R5 ack phase 100H", pw(4'hC, 1), 0, 0, 0, 0);
    sendRx(pw(4'b0111, 1));
    expectNow("R7 changed partner word restarts", pw(4'hC, 0), 0, 0, 0, 0);

    sendRx(pw(4'b0110, 0));
    repeat (TMO - 1) tick();
    expectNow("R8 before timeout still ack", pw(4'hC, 1), 0, 0, 0, 0);
    tick();
    expectNow("R8 timeout restarts", pw(4'hC, 0), 0, 0, 0, 0);

    sendRx(pw(4'b0110, 0));
    repeat (3) sendRx(pw(4'b0110, 1));
    expectNow("R4 resolve 100 half", 16'h0, 1, 1, 0, 0);

    anEnable = 1'b0; tick();
    expectNow("R1 disable clears", 16'h0, 0, 0, 0, 0);
    sendRx(pw(4'b0110, 0));
    expectNow("R1 rx ignored while disabled", 16'h0, 0, 0, 0, 0);
    anEnable = 1'b1; tick();
    expectNow("R2 re-enable restarts", pw(4'hC, 0), 0, 0, 0, 0);

    tick();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule